// File: doc/BRIEF.md
# Serial-Loaded Dot-Matrix Character Store and Row Scanner

This block is the receiving side of a small dot-matrix character display. A host sends framed 8-bit words over three wires: an active-low frame strobe, a serial clock and a data line. Each word holds a 3-bit command in its top bits and a 5-bit payload in its low bits. When the frame strobe returns high, the command is decoded. The payload then goes to one of three places: the character pointer, one row of the character store, or a control register.

The character store keeps eight characters of five rows each, with five column bits per row, so 200 bits in all. A write names only the row, in its command field. The character comes from the pointer that an earlier word set. A scanner paces itself with a mux-clock enable divided by 320. It walks through every row of every character and drives a one-hot row strobe together with the column bits of the row it is showing. The serial writes and the scan reads are independent of each other. A separate combinational read port lets a test environment inspect any stored row.

All inputs are sampled by the block clock `clk`. The serial clock and the frame strobe must each stay at one level for at least two `clk` cycles.

Top module: `disp_ram_rx`

## Requirements
- R1: Bits on `sdi` are shifted in only on a rising edge of `sck` while `frame_n` is low. The first bit shifted in becomes D0. The falling edge of `frame_n` clears the shift register.
- R2: A word is decoded in the first `clk` cycle in which `frame_n` is seen high again after being low. The decoded word is the last eight bits shifted in, oldest as D0, so any earlier bits in a frame longer than eight are discarded.
- R3: Command 3'b101 (D7..D5) loads D4..D0 into the character pointer. Only pointer bits 2..0 select one of the eight characters.
- R4: Commands 3'b000 to 3'b100 store D4..D0 into the row numbered by the command, in the character selected by the pointer. No other stored row changes.
- R5: Command 3'b110 loads D4..D0 onto `ctrl_word`. The store and the pointer are left unchanged.
- R6: Command 3'b111 changes nothing: not the store, not the pointer, not `ctrl_word`.
- R7: The scan advances exactly once for every 320 cycles in which `mux_tick` is high. `row_hot` is always one-hot, with bit r set for row r.
- R8: The scan goes through rows 0 to 4 of one character, then moves on to row 0 of the next character. After character 7 it wraps to character 0.
- R9: `col_out` equals the stored row that is being scanned, with bit i equal to payload bit Di. A write to that row shows on `col_out` from the cycle after the decode.
- R10: After reset, every stored row is zero, the pointer and `ctrl_word` are zero, and the scan sits at character 0, row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe for serial words |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, D0 first |
| mux_tick | input | 1 | One-cycle enable from the mux clock |
| row_hot | output | 5 | One-hot strobe for the scanned row |
| col_out | output | 5 | Column bits of the scanned row |
| scan_char | output | 3 | Character being scanned |
| ctrl_word | output | 5 | Last control payload received |
| rd_char | input | 3 | Inspection port character select |
| rd_row | input | 3 | Inspection port row select (0 to 4) |
| rd_cols | output | 5 | Stored bits of the inspected row |

## Verification
Two activities can land in the same cycle: a store write from the serial side, and a scan step or scan read. The bench stops the scan on a row and rewrites that row. It then checks that `col_out` follows the new value. In a second test the bench places the last of 320 mux ticks in the same cycle as a frame's closing edge. There it checks that the scan has moved to the next row, that the new row shows its own earlier contents, and that the write reached the row that was left.

// File: rtl/dr_pkg.sv
package dr_pkg;
    localparam int ROWS    = 5;
    localparam int DATA_W  = 5;
    localparam int WORD_W  = 8;
    localparam int OP_W    = 3;

    localparam logic [OP_W-1:0] OP_PTR  = 3'b101;
    localparam logic [OP_W-1:0] OP_CTRL = 3'b110;
    localparam logic [OP_W-1:0] OP_NOP  = 3'b111;
endpackage

// File: rtl/dr_shift_rx.sv
module dr_shift_rx
    import dr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              sck,
    input  logic              sdi,
    output logic [WORD_W-1:0] word,
    output logic              strobe
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic              sck;
        logic              frm;
    } rx_t;

    rx_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.sck = sck;
        s_d.frm = frame_n;
        if (!frame_n && s_q.frm) begin
            s_d.sr = '0;
        end else if (!frame_n && sck && !s_q.sck) begin
            s_d.sr = {sdi, s_q.sr[WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sr: '0, sck: 1'b0, frm: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign word   = s_q.sr;
    assign strobe = frame_n && !s_q.frm;

    AST_SHIFT_FROZEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |=> $stable(s_q.sr)); // R1
endmodule

// File: rtl/dr_store.sv
module dr_store
    import dr_pkg::*;
#(
    parameter int NCHAR = 8,
    localparam int CW   = $clog2(NCHAR),
    localparam int NENT = NCHAR * ROWS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [WORD_W-1:0] word,
    input  logic [CW-1:0]     scan_char,
    input  logic [2:0]        scan_row,
    input  logic [CW-1:0]     rd_char,
    input  logic [2:0]        rd_row,
    output logic [DATA_W-1:0] scan_cols,
    output logic [DATA_W-1:0] rd_cols,
    output logic [DATA_W-1:0] ctrl_word
);
    typedef struct packed {
        logic [NENT-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]           ptr;
        logic [DATA_W-1:0]           ctrl;
    } st_t;

    st_t s_d, s_q;

    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] pay;
    assign op  = word[WORD_W-1 -: OP_W];
    assign pay = word[DATA_W-1:0];

    function automatic int ent_idx(input logic [CW-1:0] c, input logic [2:0] r);
        return int'(c) * ROWS + int'(r);
    endfunction

    always_comb begin
        s_d = s_q;
        if (strobe) begin
            if (op == OP_PTR) begin
                s_d.ptr = pay;
            end else if (op == OP_CTRL) begin
                s_d.ctrl = pay;
            end else if (int'(op) < ROWS) begin
                s_d.mem[ent_idx(s_q.ptr[CW-1:0], op)] = pay;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        scan_cols = '0;
        rd_cols   = '0;
        if (int'(scan_row) < ROWS) scan_cols = s_q.mem[ent_idx(scan_char, scan_row)];
        if (int'(rd_row) < ROWS)   rd_cols   = s_q.mem[ent_idx(rd_char, rd_row)];
    end

    assign ctrl_word = s_q.ctrl;

    AST_PTR_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && op == OP_PTR) |=> $stable(s_q.ptr)); // R3
    AST_CTRL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op == OP_CTRL) |=> (ctrl_word == $past(pay))); // R5
    AST_NOP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op == OP_NOP) |=> ($stable(s_q.mem) && $stable(s_q.ptr) && $stable(ctrl_word))); // R6
endmodule

// File: rtl/dr_scan.sv
module dr_scan
    import dr_pkg::*;
#(
    parameter int NCHAR = 8,
    parameter int DIV   = 320,
    localparam int CW   = $clog2(NCHAR),
    localparam int DW   = $clog2(DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [2:0]       row,
    output logic [CW-1:0]    chr,
    output logic [ROWS-1:0]  row_hot
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [2:0]    row;
        logic [CW-1:0] chr;
    } sc_t;

    sc_t s_d, s_q;
    logic step;

    assign step = tick && (int'(s_q.cnt) == DIV - 1);

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.cnt = step ? '0 : s_q.cnt + 1'b1;
        end
        if (step) begin
            if (int'(s_q.row) == ROWS - 1) begin
                s_d.row = '0;
                s_d.chr = (int'(s_q.chr) == NCHAR - 1) ? '0 : s_q.chr + 1'b1;
            end else begin
                s_d.row = s_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign row = s_q.row;
    assign chr = s_q.chr;

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_hot
            assign row_hot[r] = (int'(s_q.row) == r);
        end
    endgenerate

    AST_ROW_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_hot) == 1); // R7
    AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.cnt) < DIV); // R7
    AST_CHAR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && int'(row) == ROWS - 1) |=> (row == '0 && chr != $past(chr))); // R8
endmodule

// File: rtl/disp_ram_rx.sv
module disp_ram_rx
    import dr_pkg::*;
#(
    parameter int NCHAR = 8,
    parameter int DIV   = 320,
    localparam int CW   = $clog2(NCHAR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              mux_tick,
    output logic [ROWS-1:0]   row_hot,
    output logic [DATA_W-1:0] col_out,
    output logic [CW-1:0]     scan_char,
    output logic [DATA_W-1:0] ctrl_word,
    input  logic [CW-1:0]     rd_char,
    input  logic [2:0]        rd_row,
    output logic [DATA_W-1:0] rd_cols
);
    logic [WORD_W-1:0] word;
    logic              strobe;
    logic [2:0]        scan_row;

    dr_shift_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .sck     (sck),
        .sdi     (sdi),
        .word    (word),
        .strobe  (strobe)
    );

    dr_store #(.NCHAR(NCHAR)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .word      (word),
        .scan_char (scan_char),
        .scan_row  (scan_row),
        .rd_char   (rd_char),
        .rd_row    (rd_row),
        .scan_cols (col_out),
        .rd_cols   (rd_cols),
        .ctrl_word (ctrl_word)
    );

    dr_scan #(.NCHAR(NCHAR), .DIV(DIV)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (mux_tick),
        .row     (scan_row),
        .chr     (scan_char),
        .row_hot (row_hot)
    );
endmodule

// File: tb/disp_ram_rx_bench.sv
module disp_ram_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       mux_tick = 1'b0;
    logic [2:0] rd_char = '0;
    logic [2:0] rd_row = '0;
    logic [4:0] row_hot, col_out, ctrl_word, rd_cols;
    logic [2:0] scan_char;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    disp_ram_rx u_disp_ram_rx (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sck(sck), .sdi(sdi),
        .mux_tick(mux_tick), .row_hot(row_hot), .col_out(col_out),
        .scan_char(scan_char), .ctrl_word(ctrl_word),
        .rd_char(rd_char), .rd_row(rd_row), .rd_cols(rd_cols)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; frame_n = 1'b1; sck = 1'b0; mux_tick = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(2);
    endtask

    // Sends nbits from bits, bit 0 first; optional mux tick on the closing edge.
    task automatic send(input logic [15:0] bits, input int nbits, input bit tick_at_end);
        frame_n = 1'b0;
        cyc(2);
        for (int i = 0; i < nbits; i++) begin
            sdi = bits[i]; sck = 1'b0;
            cyc(2);
            sck = 1'b1;
            cyc(2);
        end
        sck = 1'b0;
        cyc(1);
        frame_n = 1'b1;
        mux_tick = tick_at_end;
        cyc(1);
        mux_tick = 1'b0;
        cyc(3);
    endtask

    task automatic send_word(input logic [7:0] w);
        send({8'h00, w}, 8, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            mux_tick = 1'b1; cyc(1);
            mux_tick = 1'b0; cyc(1);
        end
    endtask

    function automatic int peek_idx(input int c, input int r);
        return c * 8 + r;
    endfunction

    task automatic peek(input int c, input int r, output logic [4:0] v);
        rd_char = c[2:0]; rd_row = r[2:0];
        #1;
        v = rd_cols;
    endtask

    task automatic t_reset();
        logic [4:0] v;
        do_reset();
        chk("R10 row_hot", row_hot, 5'b00001);
        chk("R10 scan_char", scan_char, 0);
        chk("R10 ctrl_word", ctrl_word, 0);
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 5; r++) begin
                peek(c, r, v);
                chk("R10 store zero", v, 0);
            end
    endtask

    task automatic t_writes();
        logic [4:0] v;
        do_reset();
        send_word({3'b101, 5'd3});
        for (int r = 0; r < 5; r++) send_word({r[2:0], 5'(r * 5 + 3)});
        for (int r = 0; r < 5; r++) begin
            peek(3, r, v);
            chk("R4 row write", v, (r * 5 + 3) & 31);
        end
        peek(2, 0, v); chk("R4 neighbour untouched", v, 0);
        peek(4, 4, v); chk("R4 neighbour untouched", v, 0);
        send_word({3'b101, 5'b11110});
        send_word({3'b010, 5'h11});
        peek(6, 2, v); chk("R3 low pointer bits", v, 5'h11);
        peek(3, 2, v); chk("R3 old char kept", v, 13);
    endtask

    task automatic t_ctrl_nop();
        logic [4:0] v;
        do_reset();
        send_word({3'b101, 5'd1});
        send_word({3'b001, 5'h0C});
        send_word({3'b110, 5'h1B});
        chk("R5 ctrl_word", ctrl_word, 5'h1B);
        peek(1, 1, v); chk("R5 store intact", v, 5'h0C);
        send_word({3'b111, 5'h07});
        chk("R6 ctrl unchanged", ctrl_word, 5'h1B);
        send_word({3'b000, 5'h05});
        peek(1, 0, v); chk("R6 pointer unchanged", v, 5'h05);
        for (int c = 0; c < 8; c++) begin
            peek(c, 7 & 3'd0, v);
            if (c != 1) chk("R6 no stray write", v, 0);
        end
    endtask

    task automatic t_framing();
        logic [4:0] v;
        do_reset();
        send_word({3'b101, 5'd5});
        // two leading bits (1,1) then the word, D0 first
        send({6'h00, 3'b100, 5'h16, 2'b11}, 10, 1'b0);
        peek(5, 4, v); chk("R2 last eight bits used", v, 5'h16);
        // serial clock edges with frame high must not shift
        sck = 1'b0; sdi = 1'b1; cyc(2); sck = 1'b1; cyc(2); sck = 1'b0; cyc(2);
        send_word({3'b011, 5'h09});
        peek(5, 3, v); chk("R1 LSB first, idle clocks ignored", v, 5'h09);
    endtask

    task automatic t_scan();
        do_reset();
        ticks(319);
        chk("R7 no step before 320", row_hot, 5'b00001);
        ticks(1);
        chk("R7 step at 320", row_hot, 5'b00010);
        ticks(320 * 3);
        chk("R8 row 4", row_hot, 5'b10000);
        chk("R8 still char 0", scan_char, 0);
        ticks(320);
        chk("R8 next char", scan_char, 1);
        chk("R8 row 0 again", row_hot, 5'b00001);
        ticks(320 * 35);
        chk("R8 wrap to char 0", scan_char, 0);
        chk("R8 wrap row 0", row_hot, 5'b00001);
    endtask

    task automatic t_collide();
        logic [4:0] v;
        do_reset();
        send_word({3'b101, 5'd0});
        send_word({3'b000, 5'h15});
        chk("R9 col_out follows write", col_out, 5'h15);
        send_word({3'b001, 5'h0A});
        chk("R9 other row not shown", col_out, 5'h15);
        ticks(319);
        send({8'h00, 3'b000, 5'h13}, 8, 1'b1);
        chk("R9 step with write: row", row_hot, 5'b00010);
        chk("R9 step with write: cols", col_out, 5'h0A);
        peek(0, 0, v); chk("R9 write landed", v, 5'h13);
    endtask

    initial begin
        t_reset();
        t_writes();
        t_ctrl_nop();
        t_framing();
        t_scan();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule